// File: doc/BRIEF.md
# Peripheral Register Space Access Decoder

This block sits between an 8-bit processor's load/store and I/O execution paths and a flat file of peripheral registers. Every request names one of seven access kinds. Short I/O-instruction reads and writes carry a 6-bit register number. Data-space reads and writes carry a full 8-bit address. Single-bit set, clear and test operations carry a 5-bit register number and a bit index. The decoder maps each request onto the shared register file, where data address = I/O number + 0x20. It refuses requests that fall outside the window their kind is allowed to reach, and refuses any write to the reserved top of the space. Status-flag bits follow write-one-to-clear rules, so a bit operation never disturbs neighbouring flags.

The block is controlled by a four-state machine. In `S_IDLE`, `req_ready` is high; a request is captured when `req_valid` is high (transition *accept*), and the machine moves to `S_DECODE`. In `S_DECODE` the request is translated into a data address and an error verdict (transition *decoded*), and the machine moves to `S_EXEC`. In `S_EXEC` the addressed word is read, the new value is merged and written back unless the request was refused, and the read result is captured (transition *executed*); the machine then moves to `S_RESP`. `S_RESP` shows the response for exactly one cycle and returns to `S_IDLE` (transition *retire*). Peripheral hardware raises flags through `evt_set`.

The register file stores every address. Addresses 0x36 and 0x37 are flag registers, and their bits 3:0 are write-one-to-clear flags. Bit 7 of every register whose address ends in binary 111 is reserved. Data addresses 0xE0–0xFF are reserved.

Top module: `iosd_top`

## Requirements
- R1: After reset every register reads 0x00. `rsp_valid` and `rsp_err` are low, and `req_ready` is high.
- R2: Kind codes are: 0 I/O read, 1 I/O write, 2 data read, 3 data write, 4 bit set, 5 bit clear, 6 bit test. Code 7 is refused. An I/O access to number n (n < 0x40) reaches the same register as a data access to n + 0x20.
- R3: An I/O read or write with an address of 0x40 or above sets `rsp_err`, returns 0x00 and changes no register.
- R4: Data accesses reach every address from 0x20 to 0xDF, including the extended range 0x60–0xDF. A data access below 0x20 sets `rsp_err` and returns 0x00.
- R5: A bit set, clear or test whose address is 0x20 or above sets `rsp_err` and changes no register.
- R6: Bit set and bit clear change only the addressed bit. On a flag bit, a set clears that one flag and a clear has no effect. Other flags are never cleared.
- R7: A byte write to a flag register clears the flag bits written as 1 and keeps the flag bits written as 0. The non-flag bits take the written value.
- R8: A high bit of `evt_set` (slice k for flag register 0x36 + k) sets the matching flag bit. Positions that are not flags are ignored.
- R9: A write of any kind to data addresses 0xE0–0xFF sets `rsp_err` and stores nothing. A read there returns 0x00 without error.
- R10: Reserved bit 7 of registers at addresses ending in binary 111 always reads 0, whatever is written.
- R11: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the response ends. `rsp_valid` is high for exactly the one cycle that starts at the third edge after acceptance.
- R12: A bit test returns the addressed bit on `rsp_bit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Decoder idle and able to accept |
| req_kind | input | 3 | Access kind code (R2) |
| req_addr | input | 8 | I/O number, bit-op number or data address |
| req_bit | input | 3 | Bit index for bit operations |
| req_wdata | input | 8 | Byte write data |
| evt_set | input | 16 | Per-flag-register hardware set requests |
| rsp_valid | output | 1 | Response cycle |
| rsp_rdata | output | 8 | Register value read (0 on error) |
| rsp_bit | output | 1 | Addressed bit for a bit test |
| rsp_err | output | 1 | Request refused |

## Verification
The bench targets the window edges: I/O number 0x40, bit-op number 0x20 and data address 0x1F. A decoder that wrapped or truncated these addresses would write into 0x20 or 0x40 instead of refusing the request, and a follow-up read of those registers exposes it. On flag registers, the bench applies a bit set, a bit clear and a byte write with mixed ones and zeros. A design that did read-modify-write of the whole byte would wipe out sibling flags, and one without clear-on-one would leave them set. The reserved top range and reserved bit 7 are written and read back: a leak would show up as nonzero data. Every request also checks the exact response cycle and that the response lasts one cycle.

// File: rtl/iosd_pkg.sv
package iosd_pkg;
    typedef enum logic [2:0] {
        K_IO_RD  = 3'd0,
        K_IO_WR  = 3'd1,
        K_DS_RD  = 3'd2,
        K_DS_WR  = 3'd3,
        K_BSET   = 3'd4,
        K_BCLR   = 3'd5,
        K_BTST   = 3'd6,
        K_BAD    = 3'd7
    } kind_t;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_DECODE = 2'd1,
        S_EXEC   = 2'd2,
        S_RESP   = 2'd3
    } state_t;

    function automatic logic kind_writes(kind_t k);
        return (k == K_IO_WR) || (k == K_DS_WR) || (k == K_BSET) || (k == K_BCLR);
    endfunction

    function automatic logic kind_is_bit(kind_t k);
        return (k == K_BSET) || (k == K_BCLR) || (k == K_BTST);
    endfunction
endpackage

// File: rtl/iosd_addr_map.sv
module iosd_addr_map
    import iosd_pkg::*;
#(
    parameter int AW      = 8,
    parameter int IO_AW   = 6,
    parameter int BIT_AW  = 5,
    parameter int RSVD_LO = 224
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chk_en,
    input  kind_t         kind,
    input  logic [AW-1:0] addr,
    output logic [AW-1:0] daddr,
    output logic          err
);
    localparam int IO_SPAN  = 1 << IO_AW;
    localparam int BIT_SPAN = 1 << BIT_AW;
    localparam int IO_OFF   = BIT_SPAN;

    logic in_win;

    always_comb begin
        daddr  = addr;
        in_win = 1'b0;
        unique case (kind)
            K_IO_RD, K_IO_WR: begin
                in_win = int'(addr) < IO_SPAN;
                daddr  = addr + AW'(IO_OFF);
            end
            K_DS_RD, K_DS_WR: begin
                in_win = int'(addr) >= IO_OFF;
            end
            K_BSET, K_BCLR, K_BTST: begin
                in_win = int'(addr) < BIT_SPAN;
                daddr  = addr + AW'(IO_OFF);
            end
            default: in_win = 1'b0;
        endcase
        err = !in_win || (kind_writes(kind) && int'(daddr) >= RSVD_LO);
    end

    // R5: accepted bit operations land inside the bit window of the space
    p_bit_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en && kind_is_bit(kind) && !err) |->
            (int'(daddr) >= IO_OFF && int'(daddr) < IO_OFF + BIT_SPAN));

    // R3: accepted I/O accesses land inside the I/O image
    p_io_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en && (kind == K_IO_RD || kind == K_IO_WR) && !err) |->
            (int'(daddr) >= IO_OFF && int'(daddr) < IO_OFF + IO_SPAN));

    // R4: accepted data accesses never reach below the I/O image
    p_ds_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en && (kind == K_DS_RD || kind == K_DS_WR) && !err) |->
            int'(daddr) >= IO_OFF);
endmodule

// File: rtl/iosd_regfile.sv
module iosd_regfile #(
    parameter int          AW        = 8,
    parameter int          DW        = 8,
    parameter int          RSVD_LO   = 224,
    parameter int          FLAG_LO   = 54,
    parameter int          FLAG_CNT  = 2,
    parameter logic [DW-1:0] FLAG_MASK = 8'h0F
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [AW-1:0]          wr_addr,
    input  logic [DW-1:0]          wr_data,
    input  logic [FLAG_CNT*DW-1:0] evt_set,
    input  logic [AW-1:0]          rd_addr,
    output logic [DW-1:0]          rd_data,
    output logic [DW-1:0]          rd_w1c,
    output logic [DW-1:0]          rd_rsvd
);
    localparam int DEPTH = 1 << AW;
    localparam logic [DW-1:0] TOP_BIT = DW'(1) << (DW - 1);

    logic [DW-1:0] word [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        localparam bit IS_FLAG = (i >= FLAG_LO) && (i < FLAG_LO + FLAG_CNT);
        localparam logic [DW-1:0] RSV = ((i % 8) == 7) ? TOP_BIT : '0;
        logic [DW-1:0] q;
        logic [DW-1:0] ev;
        if (IS_FLAG) begin : g_flag
            assign ev = evt_set[(i - FLAG_LO)*DW +: DW] & FLAG_MASK & ~RSV;
        end else begin : g_plain
            assign ev = '0;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= '0;
            else if (wr_en && int'(wr_addr) == i)
                q <= (wr_data & ~RSV) | ev;
            else
                q <= q | ev;
        end
        assign word[i] = q;
    end

    always_comb begin
        rd_data = word[rd_addr];
        rd_rsvd = (rd_addr[2:0] == 3'b111) ? TOP_BIT : '0;
        rd_w1c  = '0;
        if (int'(rd_addr) >= FLAG_LO && int'(rd_addr) < FLAG_LO + FLAG_CNT)
            rd_w1c = FLAG_MASK & ~rd_rsvd;
    end

    // R9: nothing is ever stored into the reserved address range
    p_no_rsvd_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> int'(wr_addr) < RSVD_LO);

    // R10: the merge logic never presents a one on a reserved bit
    p_rsvd_bit_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[2:0] == 3'b111) |-> !wr_data[DW-1]);
endmodule

// File: rtl/iosd_top.sv
module iosd_top
    import iosd_pkg::*;
#(
    parameter int AW       = 8,
    parameter int DW       = 8,
    parameter int IO_AW    = 6,
    parameter int BIT_AW   = 5,
    parameter int RSVD_LO  = 224,
    parameter int FLAG_LO  = 54,
    parameter int FLAG_CNT = 2,
    parameter logic [7:0] FLAG_MASK = 8'h0F,
    localparam int BW = $clog2(DW)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [2:0]             req_kind,
    input  logic [AW-1:0]          req_addr,
    input  logic [BW-1:0]          req_bit,
    input  logic [DW-1:0]          req_wdata,
    input  logic [FLAG_CNT*DW-1:0] evt_set,
    output logic                   rsp_valid,
    output logic [DW-1:0]          rsp_rdata,
    output logic                   rsp_bit,
    output logic                   rsp_err
);
    state_t        state;
    kind_t         kind_q;
    logic [AW-1:0] addr_q, daddr_q, map_daddr;
    logic [BW-1:0] bit_q;
    logic [DW-1:0] wdata_q, rdata_q;
    logic          err_q, bitv_q, map_err;
    logic          wr_en;
    logic [DW-1:0] old_v, w1c_m, rsv_m, new_v, sel;

    iosd_addr_map #(.AW(AW), .IO_AW(IO_AW), .BIT_AW(BIT_AW), .RSVD_LO(RSVD_LO)) u_map (
        .clk(clk), .rst_n(rst_n), .chk_en(state == S_DECODE),
        .kind(kind_q), .addr(addr_q), .daddr(map_daddr), .err(map_err)
    );

    iosd_regfile #(.AW(AW), .DW(DW), .RSVD_LO(RSVD_LO), .FLAG_LO(FLAG_LO),
                   .FLAG_CNT(FLAG_CNT), .FLAG_MASK(FLAG_MASK)) u_rf (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(daddr_q),
        .wr_data(new_v), .evt_set(evt_set), .rd_addr(daddr_q),
        .rd_data(old_v), .rd_w1c(w1c_m), .rd_rsvd(rsv_m)
    );

    // merge of the stored byte with the request
    always_comb begin
        sel   = DW'(1) << bit_q;
        new_v = old_v;
        unique case (kind_q)
            K_IO_WR, K_DS_WR: new_v = (req_w_plain(wdata_q, w1c_m)) | (old_v & w1c_m & ~wdata_q);
            K_BSET:           new_v = (old_v | (sel & ~w1c_m)) & ~(sel & w1c_m);
            K_BCLR:           new_v = old_v & ~(sel & ~w1c_m);
            default:          new_v = old_v;
        endcase
        new_v = new_v & ~rsv_m;
    end

    function automatic logic [DW-1:0] req_w_plain(logic [DW-1:0] d, logic [DW-1:0] m);
        return d & ~m;
    endfunction

    // state register and captured data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            kind_q  <= K_IO_RD;
            addr_q  <= '0;
            bit_q   <= '0;
            wdata_q <= '0;
            daddr_q <= '0;
            err_q   <= 1'b0;
            rdata_q <= '0;
            bitv_q  <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (req_valid) begin
                    kind_q  <= kind_t'(req_kind);
                    addr_q  <= req_addr;
                    bit_q   <= req_bit;
                    wdata_q <= req_wdata;
                    state   <= S_DECODE;
                end
                S_DECODE: begin
                    daddr_q <= map_daddr;
                    err_q   <= map_err;
                    state   <= S_EXEC;
                end
                S_EXEC: begin
                    rdata_q <= err_q ? '0 : (old_v & ~rsv_m);
                    bitv_q  <= err_q ? 1'b0 : old_v[bit_q];
                    state   <= S_RESP;
                end
                S_RESP: state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // outputs per state
    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        wr_en     = 1'b0;
        unique case (state)
            S_IDLE:   req_ready = 1'b1;
            S_DECODE: ;
            S_EXEC:   wr_en = !err_q && kind_writes(kind_q);
            S_RESP:   rsp_valid = 1'b1;
            default:  ;
        endcase
    end

    assign rsp_rdata = rdata_q;
    assign rsp_bit   = bitv_q;
    assign rsp_err   = err_q;

    // R11: response is a single-cycle pulse
    p_rsp_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R11: acceptance drops ready on the next cycle
    p_busy_after_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R11: response arrives at the third edge after acceptance
    p_rsp_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> ##3 rsp_valid);

    // R3: a refused request never reports data
    p_err_zero_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_rdata == '0 && !rsp_bit));
endmodule

// File: tb/iosd_top_tb.sv
module iosd_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_kind = '0;
    logic [7:0]  req_addr = '0;
    logic [2:0]  req_bit = '0;
    logic [7:0]  req_wdata = '0;
    logic [15:0] evt_set = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic        rsp_bit;
    logic        rsp_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [2:0] IO_RD = 3'd0, IO_WR = 3'd1, DS_RD = 3'd2, DS_WR = 3'd3,
                           BSET = 3'd4, BCLR = 3'd5, BTST = 3'd6;

    iosd_top u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_addr(req_addr), .req_bit(req_bit),
        .req_wdata(req_wdata), .evt_set(evt_set), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rsp_bit(rsp_bit), .rsp_err(rsp_err)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // one request with full R11 timing checks
    task automatic access(input logic [2:0] k, input logic [7:0] a, input logic [2:0] b,
                          input logic [7:0] d, output logic [7:0] rd,
                          output logic bv, output logic er);
        @(negedge clk);
        chk(req_ready === 1'b1, "R11 ready when idle", int'(req_ready), 1);
        req_valid = 1'b1; req_kind = k; req_addr = a; req_bit = b; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready === 1'b0 && rsp_valid === 1'b0, "R11 busy after accept",
            int'({req_ready, rsp_valid}), 0);
        @(negedge clk);
        chk(rsp_valid === 1'b0, "R11 no early response", int'(rsp_valid), 0);
        @(negedge clk);
        chk(rsp_valid === 1'b1, "R11 response cycle", int'(rsp_valid), 1);
        rd = rsp_rdata; bv = rsp_bit; er = rsp_err;
        @(negedge clk);
        chk(rsp_valid === 1'b0 && req_ready === 1'b1, "R11 single pulse",
            int'({rsp_valid, req_ready}), 1);
    endtask

    task automatic expect_rd(input logic [2:0] k, input logic [7:0] a, input logic [7:0] exp_d,
                             input logic exp_e, input string tag);
        logic [7:0] rd; logic bv, er;
        access(k, a, 3'd0, 8'h00, rd, bv, er);
        chk(rd === exp_d, tag, int'(rd), int'(exp_d));
        chk(er === exp_e, tag, int'(er), int'(exp_e));
    endtask

    task automatic do_wr(input logic [2:0] k, input logic [7:0] a, input logic [2:0] b,
                         input logic [7:0] d, input logic exp_e, input string tag);
        logic [7:0] rd; logic bv, er;
        access(k, a, b, d, rd, bv, er);
        chk(er === exp_e, tag, int'(er), int'(exp_e));
    endtask

    task automatic t_reset_r1();
        chk(req_ready === 1'b1 && rsp_valid === 1'b0 && rsp_err === 1'b0, "R1 idle outputs",
            int'({req_ready, rsp_valid, rsp_err}), 4);
        expect_rd(DS_RD, 8'h40, 8'h00, 1'b0, "R1 reset value 0x40");
        expect_rd(IO_RD, 8'h16, 8'h00, 1'b0, "R1 reset value flag reg");
    endtask

    task automatic t_dual_map_r2();
        do_wr(IO_WR, 8'h05, 3'd0, 8'hA5, 1'b0, "R2 io write");
        expect_rd(DS_RD, 8'h25, 8'hA5, 1'b0, "R2 io->data image");
        do_wr(DS_WR, 8'h3A, 3'd0, 8'h3C, 1'b0, "R2 data write");
        expect_rd(IO_RD, 8'h1A, 8'h3C, 1'b0, "R2 data->io image");
    endtask

    task automatic t_io_range_r3();
        do_wr(IO_WR, 8'h40, 3'd0, 8'hFF, 1'b1, "R3 io write past window");
        expect_rd(IO_RD, 8'h41, 8'h00, 1'b1, "R3 io read past window");
        expect_rd(DS_RD, 8'h60, 8'h00, 1'b0, "R3 no write at 0x60");
        expect_rd(DS_RD, 8'h20, 8'h00, 1'b0, "R3 no wrapped write at 0x20");
    endtask

    task automatic t_extended_r4();
        do_wr(DS_WR, 8'h90, 3'd0, 8'h5A, 1'b0, "R4 extended write");
        expect_rd(DS_RD, 8'h90, 8'h5A, 1'b0, "R4 extended read");
        do_wr(DS_WR, 8'hDF, 3'd0, 8'h11, 1'b0, "R4 last usable write");
        expect_rd(DS_RD, 8'hDF, 8'h11, 1'b0, "R4 last usable read");
        expect_rd(DS_RD, 8'h1F, 8'h00, 1'b1, "R4 below window refused");
    endtask

    task automatic t_bit_window_r5();
        logic [7:0] rd; logic bv, er;
        do_wr(BSET, 8'h20, 3'd0, 8'h00, 1'b1, "R5 bit set past window");
        expect_rd(DS_RD, 8'h40, 8'h00, 1'b0, "R5 0x40 untouched");
        expect_rd(DS_RD, 8'h20, 8'h00, 1'b0, "R5 0x20 untouched");
        do_wr(DS_WR, 8'h45, 3'd0, 8'hF0, 1'b0, "R5 preset 0x45");
        do_wr(BCLR, 8'h25, 3'd4, 8'h00, 1'b1, "R5 bit clear past window");
        expect_rd(DS_RD, 8'h45, 8'hF0, 1'b0, "R5 0x45 untouched");
        access(BTST, 8'h3F, 3'd0, 8'h00, rd, bv, er);
        chk(er === 1'b1, "R5 bit test past window", int'(er), 1);
    endtask

    task automatic t_bitops_r6();
        do_wr(DS_WR, 8'h28, 3'd0, 8'h81, 1'b0, "R6 preset");
        do_wr(BSET, 8'h08, 3'd3, 8'h00, 1'b0, "R6 set bit3");
        expect_rd(IO_RD, 8'h08, 8'h89, 1'b0, "R6 only bit3 set");
        do_wr(BCLR, 8'h08, 3'd7, 8'h00, 1'b0, "R6 clear bit7");
        expect_rd(IO_RD, 8'h08, 8'h09, 1'b0, "R6 only bit7 cleared");
    endtask

    task automatic pulse_evt(input logic [15:0] v);
        @(negedge clk);
        evt_set = v;
        @(negedge clk);
        evt_set = '0;
    endtask

    task automatic t_flags_r8_r6_r7();
        pulse_evt(16'h00FF);
        expect_rd(IO_RD, 8'h16, 8'h0F, 1'b0, "R8 only flag positions set");
        expect_rd(DS_RD, 8'h37, 8'h00, 1'b0, "R8 other flag reg untouched");
        do_wr(BSET, 8'h16, 3'd1, 8'h00, 1'b0, "R6 set on flag");
        expect_rd(IO_RD, 8'h16, 8'h0D, 1'b0, "R6 set clears one flag only");
        do_wr(BCLR, 8'h16, 3'd0, 8'h00, 1'b0, "R6 clear on flag");
        expect_rd(IO_RD, 8'h16, 8'h0D, 1'b0, "R6 clear on flag no effect");
        do_wr(BSET, 8'h16, 3'd5, 8'h00, 1'b0, "R6 set plain bit in flag reg");
        expect_rd(IO_RD, 8'h16, 8'h2D, 1'b0, "R6 plain bit set, flags kept");
        do_wr(IO_WR, 8'h16, 3'd0, 8'h64, 1'b0, "R7 byte write");
        expect_rd(IO_RD, 8'h16, 8'h69, 1'b0, "R7 mixed w1c merge");
        pulse_evt(16'h8F00);
        expect_rd(DS_RD, 8'h37, 8'h0F, 1'b0, "R8 second flag reg set");
    endtask

    task automatic t_bittest_r12();
        logic [7:0] rd; logic bv, er;
        access(BTST, 8'h16, 3'd3, 8'h00, rd, bv, er);
        chk(bv === 1'b1 && er === 1'b0, "R12 test bit3 high", int'(bv), 1);
        access(BTST, 8'h16, 3'd2, 8'h00, rd, bv, er);
        chk(bv === 1'b0 && er === 1'b0, "R12 test bit2 low", int'(bv), 0);
    endtask

    task automatic t_reserved_r9_r10();
        do_wr(DS_WR, 8'hE4, 3'd0, 8'h77, 1'b1, "R9 reserved write refused");
        expect_rd(DS_RD, 8'hE4, 8'h00, 1'b0, "R9 reserved reads zero");
        do_wr(DS_WR, 8'hFF, 3'd0, 8'h01, 1'b1, "R9 top address refused");
        expect_rd(DS_RD, 8'hFF, 8'h00, 1'b0, "R9 top address zero");
        do_wr(DS_WR, 8'h2F, 3'd0, 8'hFF, 1'b0, "R10 write all ones");
        expect_rd(DS_RD, 8'h2F, 8'h7F, 1'b0, "R10 reserved bit reads zero");
        do_wr(BSET, 8'h0F, 3'd7, 8'h00, 1'b0, "R10 set reserved bit");
        expect_rd(IO_RD, 8'h0F, 8'h7F, 1'b0, "R10 reserved bit stays zero");
        do_wr(3'd7, 8'h30, 3'd0, 8'h00, 1'b1, "R2 code 7 refused");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_r1();
        t_dual_map_r2();
        t_io_range_r3();
        t_extended_r4();
        t_bit_window_r5();
        t_bitops_r6();
        t_flags_r8_r6_r7();
        t_bittest_r12();
        t_reserved_r9_r10();
        done = 1'b1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (100000) @(posedge clk);
                chk(1'b0, "watchdog expired", 0, 1);
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule